// File: doc/BRIEF.md
# H-Bridge Command Decoder with Idle Sleep

This block turns two logic-level direction/PWM inputs into four gate enables, a high-side and a low-side enable for each of two half-bridge legs. Each input combination maps onto one of four bridge actions: coast, forward, reverse or brake. Every time a leg has to reverse from pulling up to pulling down, or from down to up, the block holds both of that leg's switches off for a programmable dead time first. This prevents shoot-through.

The block also runs a power sequencer. If both inputs stay low for a long idle period, it goes to sleep. It leaves sleep only after either input has been high continuously for a minimum time, followed by a further start-up delay. Two override requests let neighbouring protection and current-regulation logic take control of the bridge: one turns every switch off, the other brakes on both low sides. Both overrides still pass through dead-time insertion.

All timing constants are parameters counted in clock cycles. Inputs are sampled on every clock, so a clock of several MHz or more resolves any 800 ns pulse and any PWM rate up to 200 kHz.

Top module: `hb_bridge_ctrl`

## Requirements
- R1: While awake with no override, the inputs {in1,in2} select the leg states as follows. 00 turns all four enables off (coast). 10 drives leg 1 high and leg 2 low (forward). 01 drives leg 1 low and leg 2 high (reverse). 11 drives both legs low (brake). A leg that is driven high has hs=1 and ls=0. A leg that is driven low has hs=0 and ls=1. The outputs follow the inputs one clock after they are sampled, unless a dead time intervenes.
- R2: When a leg changes from high to low, or from low to high, both of its enables are 0 for exactly DEAD_CYC cycles before the new enable rises. A leg that starts from off with no dead time pending turns on in the next cycle.
- R3: The hs and ls enables of one leg are never both 1 in the same cycle.
- R4: While awake, IDLE_CYC consecutive sampled cycles with both inputs low put the block to sleep. Any cycle in which either input is high restarts that count.
- R5: After reset, sleep=1 and ready=0 at once, whatever the inputs are.
- R6: Waking requires WAKE_FILT_CYC consecutive cycles with either input high. A shorter pulse leaves the block asleep and restarts the filter. After the filter, ready rises WAKE_DLY_CYC cycles later, and all enables stay 0 until it does.
- R7: force_off=1 turns every enable off on the next cycle and outranks force_brake and the inputs.
- R8: force_brake=1 without force_off drives both legs low, whatever the inputs are.
- R9: Transitions caused by the overrides obey the same dead time as those caused by the inputs.
- R10: sleep and ready are never both 1. While asleep, and while ready=0, all enables are 0.
- R11: A one-cycle input pulse while awake produces a one-cycle change at the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in1 | input | 1 | Direction/PWM input 1 |
| in2 | input | 1 | Direction/PWM input 2 |
| force_off | input | 1 | Override: all switches off |
| force_brake | input | 1 | Override: both low sides on |
| hs1 | output | 1 | Leg 1 high-side enable |
| ls1 | output | 1 | Leg 1 low-side enable |
| hs2 | output | 1 | Leg 2 high-side enable |
| ls2 | output | 1 | Leg 2 low-side enable |
| sleep | output | 1 | Block is asleep |
| ready | output | 1 | Awake and start-up delay complete |

## Verification
The hardest state to reach is a dead-time window that overlaps a change of target. In that case a second reversal, or an override, arrives while a leg is already off and counting. It is also hard to reach the case where sleep falls due while the brake override still holds the low sides on.

The bench is run with small timing parameters. It sweeps every ordered pair of the sixteen combinations of inputs and overrides, holding each one for a few cycles, so that transitions land both inside and outside running dead times. Between the sweeps, directed sequences reach these states: idle runs that fall one cycle short, input pulses that fall one cycle short of waking, and a reset applied while the inputs are high. A cycle model written from the requirements checks every output on every cycle.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    LEG_OFF  = 2'd0,
    LEG_HIGH = 2'd1,
    LEG_LOW  = 2'd2
  } leg_cmd_t;

  typedef enum logic [1:0] {
    PS_SLEEP = 2'd0,
    PS_WAKE  = 2'd1,
    PS_RUN   = 2'd2
  } pwr_state_t;
endpackage

// File: rtl/hb_power_seq.sv
module hb_power_seq
  import hb_pkg::*;
#(
  parameter int IDLE_CYC      = 100000,
  parameter int WAKE_FILT_CYC = 500,
  parameter int WAKE_DLY_CYC  = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic sleep,
  output logic ready
);
  localparam int MAXC = (IDLE_CYC > WAKE_FILT_CYC)
                      ? ((IDLE_CYC > WAKE_DLY_CYC) ? IDLE_CYC : WAKE_DLY_CYC)
                      : ((WAKE_FILT_CYC > WAKE_DLY_CYC) ? WAKE_FILT_CYC : WAKE_DLY_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_CYC - 1);
  localparam logic [CW-1:0] FILT_LAST = CW'(WAKE_FILT_CYC - 1);
  localparam logic [CW-1:0] DLY_LAST  = CW'(WAKE_DLY_CYC - 1);

  pwr_state_t      st;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= PS_SLEEP;
      cnt <= '0;
    end else begin
      unique case (st)
        PS_SLEEP: begin
          if (!active)               cnt <= '0;
          else if (cnt == FILT_LAST) begin st <= PS_WAKE; cnt <= '0; end
          else                       cnt <= cnt + 1'b1;
        end
        PS_WAKE: begin
          if (cnt == DLY_LAST) begin st <= PS_RUN; cnt <= '0; end
          else                 cnt <= cnt + 1'b1;
        end
        PS_RUN: begin
          if (active)                cnt <= '0;
          else if (cnt == IDLE_LAST) begin st <= PS_SLEEP; cnt <= '0; end
          else                       cnt <= cnt + 1'b1;
        end
        default: begin st <= PS_SLEEP; cnt <= '0; end
      endcase
    end
  end

  assign sleep = (st == PS_SLEEP);
  assign ready = (st == PS_RUN);

  p_excl_r10: assert property (@(posedge clk) disable iff (rst) !(sleep && ready));
  p_wake_path_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(!sleep));
  p_idle_entry_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep) |-> $past(!active && ready));
endmodule

// File: rtl/hb_cmd_decode.sv
module hb_cmd_decode
  import hb_pkg::*;
(
  input  logic            in1,
  input  logic            in2,
  input  logic            force_off,
  input  logic            force_brake,
  input  logic            ready,
  output leg_cmd_t [1:0]  tgt
);
  always_comb begin
    if (!ready || force_off) begin
      tgt[0] = LEG_OFF;  tgt[1] = LEG_OFF;
    end else if (force_brake) begin
      tgt[0] = LEG_LOW;  tgt[1] = LEG_LOW;
    end else begin
      unique case ({in1, in2})
        2'b10:   begin tgt[0] = LEG_HIGH; tgt[1] = LEG_LOW;  end
        2'b01:   begin tgt[0] = LEG_LOW;  tgt[1] = LEG_HIGH; end
        2'b11:   begin tgt[0] = LEG_LOW;  tgt[1] = LEG_LOW;  end
        default: begin tgt[0] = LEG_OFF;  tgt[1] = LEG_OFF;  end
      endcase
    end
  end
endmodule

// File: rtl/hb_leg_deadband.sv
module hb_leg_deadband
  import hb_pkg::*;
#(
  parameter int DEAD_CYC = 22
) (
  input  logic     clk,
  input  logic     rst,
  input  leg_cmd_t tgt,
  output logic     hs,
  output logic     ls
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] DEAD_LOAD = DW'(DEAD_CYC - 1);

  leg_cmd_t       cur;
  logic [DW-1:0]  gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= LEG_OFF;
      gap <= '0;
    end else if (cur != LEG_OFF) begin
      if (tgt != cur) begin
        cur <= LEG_OFF;
        gap <= DEAD_LOAD;
      end
    end else if (gap != '0) begin
      gap <= gap - 1'b1;
    end else begin
      cur <= tgt;
    end
  end

  assign hs = (cur == LEG_HIGH);
  assign ls = (cur == LEG_LOW);

  p_no_shoot_r3: assert property (@(posedge clk) disable iff (rst) !(hs && ls));
  p_dead_hl_r2: assert property (@(posedge clk) disable iff (rst) $past(hs) |-> !ls);
  p_dead_lh_r2: assert property (@(posedge clk) disable iff (rst) $past(ls) |-> !hs);
endmodule

// File: rtl/hb_bridge_ctrl.sv
module hb_bridge_ctrl
  import hb_pkg::*;
#(
  parameter int DEAD_CYC      = 22,
  parameter int IDLE_CYC      = 100000,
  parameter int WAKE_FILT_CYC = 500,
  parameter int WAKE_DLY_CYC  = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic in1,
  input  logic in2,
  input  logic force_off,
  input  logic force_brake,
  output logic hs1,
  output logic ls1,
  output logic hs2,
  output logic ls2,
  output logic sleep,
  output logic ready
);
  localparam int NLEG = 2;

  leg_cmd_t [NLEG-1:0] tgt;
  logic     [NLEG-1:0] leg_hs;
  logic     [NLEG-1:0] leg_ls;

  hb_power_seq #(
    .IDLE_CYC(IDLE_CYC), .WAKE_FILT_CYC(WAKE_FILT_CYC), .WAKE_DLY_CYC(WAKE_DLY_CYC)
  ) u_pwr (
    .clk(clk), .rst(rst), .active(in1 | in2), .sleep(sleep), .ready(ready)
  );

  hb_cmd_decode u_dec (
    .in1(in1), .in2(in2), .force_off(force_off), .force_brake(force_brake),
    .ready(ready), .tgt(tgt)
  );

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    hb_leg_deadband #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk(clk), .rst(rst), .tgt(tgt[g]), .hs(leg_hs[g]), .ls(leg_ls[g])
    );
  end

  assign hs1 = leg_hs[0] & ready;
  assign ls1 = leg_ls[0] & ready;
  assign hs2 = leg_hs[1] & ready;
  assign ls2 = leg_ls[1] & ready;

  p_quiet_asleep_r10: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !(hs1 || ls1 || hs2 || ls2));
  p_force_off_r7: assert property (@(posedge clk) disable iff (rst)
    $past(force_off) |-> !(hs1 || ls1 || hs2 || ls2));
  p_brake_no_high_r8: assert property (@(posedge clk) disable iff (rst)
    $past(force_brake) |-> !(hs1 || hs2));
endmodule

// File: tb/test_hb_bridge_ctrl.sv
module test_hb_bridge_ctrl;
  localparam int DEAD = 3;
  localparam int IDLE = 40;
  localparam int WF   = 5;
  localparam int WD   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in1 = 1'b0, in2 = 1'b0, force_off = 1'b0, force_brake = 1'b0;
  logic hs1, ls1, hs2, ls2, sleep, ready;

  int n_chk = 0;
  int n_bad = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;
  string tag = "R5";

  always #2.5 clk = ~clk;

  hb_bridge_ctrl #(.DEAD_CYC(DEAD), .IDLE_CYC(IDLE), .WAKE_FILT_CYC(WF), .WAKE_DLY_CYC(WD))
    i_hb_bridge_ctrl (.clk(clk), .rst(rst), .in1(in1), .in2(in2), .force_off(force_off),
      .force_brake(force_brake), .hs1(hs1), .ls1(ls1), .hs2(hs2), .ls2(ls2),
      .sleep(sleep), .ready(ready));

  // reference model: state 0 asleep, 1 waking, 2 running; leg 0 off, 1 high, 2 low
  int m_st, m_cnt;
  int m_cur [2];
  int m_gap [2];

  always @(posedge clk) begin
    int t [2];
    if (rst) begin
      m_st = 0; m_cnt = 0;
      for (int k = 0; k < 2; k++) begin m_cur[k] = 0; m_gap[k] = 0; end
    end else begin
      if (m_st != 2 || force_off) begin t[0] = 0; t[1] = 0; end
      else if (force_brake)       begin t[0] = 2; t[1] = 2; end
      else if (in1 && !in2)       begin t[0] = 1; t[1] = 2; end
      else if (!in1 && in2)       begin t[0] = 2; t[1] = 1; end
      else if (in1 && in2)        begin t[0] = 2; t[1] = 2; end
      else                        begin t[0] = 0; t[1] = 0; end
      for (int k = 0; k < 2; k++) begin
        if (m_cur[k] != 0) begin
          if (t[k] != m_cur[k]) begin m_cur[k] = 0; m_gap[k] = DEAD - 1; end
        end else if (m_gap[k] > 0) m_gap[k] = m_gap[k] - 1;
        else m_cur[k] = t[k];
      end
      if (m_st == 0) begin
        if (in1 || in2) begin
          m_cnt = m_cnt + 1;
          if (m_cnt == WF) begin m_st = 1; m_cnt = 0; end
        end else m_cnt = 0;
      end else if (m_st == 1) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == WD) begin m_st = 2; m_cnt = 0; end
      end else begin
        if (in1 || in2) m_cnt = 0;
        else begin
          m_cnt = m_cnt + 1;
          if (m_cnt == IDLE) begin m_st = 0; m_cnt = 0; end
        end
      end
    end
  end

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {hs1,ls1,hs2,ls2,sleep,ready} actual %b expected %b at %0t",
               req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      logic [5:0] e;
      logic rdy;
      rdy = (m_st == 2);
      e = {rdy && m_cur[0] == 1, rdy && m_cur[0] == 2,
           rdy && m_cur[1] == 1, rdy && m_cur[1] == 2, m_st == 0, rdy};
      check(tag, {hs1, ls1, hs2, ls2, sleep, ready}, e);
      if ((hs1 && ls1) || (hs2 && ls2)) check("R3", 6'b1, 6'b0);
      if (sleep && ready) check("R10", 6'b1, 6'b0);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic [3:0] v);
    {in1, in2, force_off, force_brake} = v;
  endtask

  task automatic flag(input string req, input logic act, input logic exp);
    check(req, {5'b0, act}, {5'b0, exp});
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    step(3);
    rst = 1'b0;
    chk_on = 1'b1;
    step(1);
    tag = "R5";
    flag("R5 sleep after reset", sleep, 1'b1);
    flag("R5 ready after reset", ready, 1'b0);

    // R6: short pulse does not wake
    tag = "R6";
    drive(4'b1000); step(WF - 1);
    drive(4'b0000); step(2);
    flag("R6 short pulse stays asleep", sleep, 1'b1);
    drive(4'b1000);
    n = 0;
    while (!ready && n < 100) begin step(1); n++; end
    flag("R6 wake latency", n == WF + WD, 1'b1);

    // R2: reversal dead time on leg 1
    tag = "R2";
    step(3);
    drive(4'b0100);
    step(DEAD);
    flag("R2 leg1 off during dead time", hs1 | ls1, 1'b0);
    step(1);
    flag("R2 leg1 low after dead time", ls1, 1'b1);

    // R7 / R8 / R9 overrides
    tag = "R7";
    drive(4'b0110); step(1);
    flag("R7 force_off all off", hs1 | ls1 | hs2 | ls2, 1'b0);
    tag = "R8 R9";
    drive(4'b0101); step(1);
    flag("R9 brake waits dead time on leg2", hs2 | ls2, 1'b0);
    step(DEAD + 1);
    flag("R8 brake both low", {ls1, ls2} == 2'b11, 1'b1);

    // R11: single-cycle pulse
    tag = "R11";
    drive(4'b0000); step(DEAD + 2);
    drive(4'b1000); step(1);
    drive(4'b0000);
    flag("R11 pulse reaches hs1", hs1, 1'b1);
    step(1);
    flag("R11 pulse ends", hs1, 1'b0);

    // R4: idle restart then sleep
    tag = "R4";
    drive(4'b1000); step(2);
    drive(4'b0000); step(IDLE - 1);
    flag("R4 awake one short of idle", ready, 1'b1);
    drive(4'b0100); step(1);
    drive(4'b0000); step(IDLE - 1);
    flag("R4 restart keeps awake", ready, 1'b1);
    step(1);
    flag("R4 sleep after idle", sleep, 1'b1);

    // R1 R7 R8 R9 R10 R11 sweep over all ordered pairs
    tag = "R1 R7 R8 R9 R10 R11 sweep";
    drive(4'b1100); step(WF + WD + 1);
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        drive(4'(a)); step(DEAD + 2);
        drive(4'(b)); step(1 + (b % 4));
      end
    end

    // R5: reset with inputs high
    tag = "R5";
    drive(4'b1100); step(WF + WD + 2);
    chk_on = 1'b0;
    rst = 1'b1; step(2);
    rst = 1'b0; step(1);
    chk_on = 1'b1;
    flag("R5 sleep when reset with inputs high", sleep, 1'b1);
    flag("R5 no drive after reset", hs1 | ls1 | hs2 | ls2, 1'b0);
    step(2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule